// File: doc/BRIEF.md
# Keyclick Square-Wave Burst Generator

This block makes a short square-wave tone burst that is summed into an audio path as audible feedback for a key press. Software writes one 16-bit control word. That word sets the loudness, the pitch and the number of tone periods. When bit 15 is set in the word, the burst starts at once. The block counts tone periods on a reference tick of about 1 MHz. After the programmed number of periods it stops and clears bit 15 by itself. Software can read bit 15 back to see whether the burst is still playing.

The output is a signed sample that sits at zero while the block is idle. The block needs only its own clock and the reference tick. It therefore keeps working when the main audio converters are powered down.

Control word layout: bit 15 is the enable bit. Bits [11:9] hold the amplitude code A, bits [7:4] the duration code D and bits [2:0] the frequency code F. Bits 14:12, 8 and 3 are reserved. The tone period is `BASE_PERIOD << F` reference ticks. With the default of 125 ticks at 1 MHz, this gives 8 kHz down to 62.5 Hz.

Top module: `keyclick_gen`

## Requirements
- R1: After reset, `busy` is 0, `sample` is 0 and `ctrl_rd` is 0.
- R2: A write whose bit 15 is 1 starts a burst. From the next cycle on, `busy` and `ctrl_rd[15]` are 1.
- R3: The tone period P is `BASE_PERIOD << F` reference ticks, with F = bits [2:0]. In each period, the first floor(P/2) ticks give a positive sample and the remaining ticks give a negative sample.
- R4: A burst lasts 2×(D+1) periods, with D = bits [7:4]. `busy` is high for exactly 2×(D+1)×P reference ticks.
- R5: While the burst runs, the sample magnitude is (A+1)×1024, with A = bits [11:9].
- R6: While no burst runs, `sample` is 0.
- R7: When the burst ends, `ctrl_rd[15]` returns to 0 by itself. Bits [11:9], [7:4] and [2:0] read back as written, and the reserved bits read as 0.
- R8: A write with bit 15 set during a burst restarts the period count from zero. The restarted burst uses the newly written fields.
- R9: A write with bit 15 clear stores the fields and stops any running burst in the next cycle.
- R10: The tone and period counters advance only on cycles where `ref_tick` is 1. On other cycles the output is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable at the reference rate (about 1 MHz) |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word to write |
| ctrl_rd | output | 16 | Control word read back, with the live enable bit |
| busy | output | 1 | High while a burst is playing |
| sample | output | 16 | Signed tone sample to be summed into the audio path |

## Verification
The bench measures burst lengths at the shortest and the longest settings. A design with an off-by-one in the period count would play one period too many or too few. A design that decoded the duration field wrongly would never reach 32 periods. The bench checks the sign of every sample against its position in the period. It also checks the magnitude against the amplitude code. This catches a swapped phase order, a wrong shift of the frequency code and a wrong amplitude scale.

Further tests cover three more cases:
- A write in the middle of a burst. A design that ignored it would finish the old burst. A design that kept the old count would end the burst too early.
- A write with the enable bit clear. A design that ignored it would keep playing.
- A reference tick that fires only on every other cycle. A design counting clock cycles instead of ticks would halve the burst length.

// File: rtl/kc_pkg.sv
// Package: shared field positions and the configuration type for the
// keyclick generator. Assumes a 16-bit control word with the enable bit on top.
package kc_pkg;
    localparam int WORD_W   = 16;
    localparam int EN_BIT   = 15;
    localparam int AMP_LSB  = 9;
    localparam int DUR_LSB  = 4;
    localparam int FREQ_LSB = 0;
    localparam int AMP_W    = 3;
    localparam int DUR_W    = 4;
    localparam int FREQ_W   = 3;
    // Bits that are stored and read back (amplitude, duration, frequency)
    localparam logic [WORD_W-2:0] FIELD_MASK = 15'h0EF7;

    typedef struct packed {
        logic [AMP_W-1:0]  amp;
        logic [DUR_W-1:0]  dur;
        logic [FREQ_W-1:0] freq;
    } kc_cfg_t;
endpackage

// File: rtl/kc_ctrl_reg.sv
// Control register: stores the written fields and holds the live enable bit.
// Assumes wr_en is a one-cycle strobe and burst_done is a one-cycle pulse.
// A write wins over a burst end that falls in the same cycle.
module kc_ctrl_reg
    import kc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              burst_done,
    output logic              active,
    output kc_cfg_t           cfg,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-2:0] fields_q;

    // Capture the field bits on a write; the reserved bits are stored as zero
    always_ff @(posedge clk) begin
        if (!rst_n)     fields_q <= '0;
        else if (wr_en) fields_q <= wr_data[WORD_W-2:0] & FIELD_MASK;
    end

    // Enable bit: set or cleared by a write, cleared by itself when the burst ends
    always_ff @(posedge clk) begin
        if (!rst_n)          active <= 1'b0;
        else if (wr_en)      active <= wr_data[EN_BIT];
        else if (burst_done) active <= 1'b0;
    end

    // Split the stored word into its fields
    always_comb begin
        cfg.amp  = fields_q[AMP_LSB  +: AMP_W];
        cfg.dur  = fields_q[DUR_LSB  +: DUR_W];
        cfg.freq = fields_q[FREQ_LSB +: FREQ_W];
    end

    assign rd_word = {active, fields_q};

    // R7
    end_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(wr_en) || $past(burst_done)));
endmodule

// File: rtl/kc_tone_div.sv
// Tone divider: counts reference ticks through one tone period and reports
// the phase and the last tick of each period. Assumes freq changes only
// together with a restart.
module kc_tone_div
    import kc_pkg::*;
#(
    parameter int BASE_PERIOD = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              active,
    input  logic              ref_tick,
    input  logic [FREQ_W-1:0] freq,
    output logic              phase_pos,
    output logic              period_end
);
    localparam int MAX_PERIOD = BASE_PERIOD << ((1 << FREQ_W) - 1);
    localparam int PER_W      = $clog2(MAX_PERIOD + 1);

    logic [PER_W-1:0] period_len;
    logic [PER_W-1:0] tick_cnt;

    // Period length in ticks for the selected frequency code
    assign period_len = PER_W'(BASE_PERIOD) << freq;

    // Position within the period: restarts on a write, advances on each reference tick
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active) tick_cnt <= '0;
        else if (ref_tick)                tick_cnt <= period_end ? '0 : tick_cnt + 1'b1;
    end

    assign period_end = active && ref_tick && (tick_cnt == period_len - 1'b1);
    assign phase_pos  = tick_cnt < (period_len >> 1);

    // R3
    period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt < period_len);
endmodule

// File: rtl/kc_burst_cnt.sv
// Burst counter: counts completed tone periods and flags the last one.
// Assumes dur changes only together with a restart.
module kc_burst_cnt
    import kc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             period_end,
    input  logic [DUR_W-1:0] dur,
    output logic             burst_done
);
    logic [DUR_W:0] per_cnt;
    logic [DUR_W:0] last_idx;

    // Index of the last period, 2*(D+1) - 1
    assign last_idx = {dur, 1'b1};

    // Count completed periods; wrap to zero after the last one
    always_ff @(posedge clk) begin
        if (!rst_n || restart) per_cnt <= '0;
        else if (period_end)   per_cnt <= burst_done ? '0 : per_cnt + 1'b1;
    end

    assign burst_done = period_end && (per_cnt == last_idx);

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_cnt <= last_idx);
endmodule

// File: rtl/keyclick_gen.sv
// Keyclick generator top: a written control word starts a square-wave burst.
// Outputs a signed sample of +/-(A+1)*1024 while the burst runs and zero
// when idle. Assumes ref_tick is a one-cycle pulse at the reference rate.
module keyclick_gen
    import kc_pkg::*;
#(
    parameter int BASE_PERIOD = 125,
    parameter int SAMPLE_W    = 16,
    parameter int AMP_SHIFT   = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ref_tick,
    input  logic                       wr_en,
    input  logic [15:0]                wr_data,
    output logic [15:0]                ctrl_rd,
    output logic                       busy,
    output logic signed [SAMPLE_W-1:0] sample
);
    kc_cfg_t              cfg;
    logic                 active;
    logic                 phase_pos;
    logic                 period_end;
    logic                 burst_done;
    logic [SAMPLE_W-1:0]  magnitude;

    kc_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .burst_done (burst_done),
        .active     (active),
        .cfg        (cfg),
        .rd_word    (ctrl_rd)
    );

    kc_tone_div #(.BASE_PERIOD(BASE_PERIOD)) u_tone (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (wr_en),
        .active     (active),
        .ref_tick   (ref_tick),
        .freq       (cfg.freq),
        .phase_pos  (phase_pos),
        .period_end (period_end)
    );

    kc_burst_cnt u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (wr_en),
        .period_end (period_end),
        .dur        (cfg.dur),
        .burst_done (burst_done)
    );

    // Sample magnitude from the amplitude code
    assign magnitude = (SAMPLE_W'(cfg.amp) + 1'b1) << AMP_SHIFT;

    // Signed output: positive half, negative half, or zero when idle
    always_comb begin
        if (!active)        sample = '0;
        else if (phase_pos) sample = magnitude;
        else                sample = -magnitude;
    end

    assign busy = active;

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[EN_BIT]) |=> busy);

    // R5
    live_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sample != '0));

    // R10
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ref_tick && !wr_en) |=> $stable(sample));
endmodule

// File: tb/test_keyclick_gen.sv
// Directed bench for keyclick_gen; BASE_PERIOD is shrunk to keep runs short.
module test_keyclick_gen;
    localparam int BP = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ref_tick = 1'b1;
    logic               wr_en = 1'b0;
    logic [15:0]        wr_data = '0;
    logic [15:0]        ctrl_rd;
    logic               busy;
    logic signed [15:0] sample;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    keyclick_gen #(.BASE_PERIOD(BP)) i_keyclick_gen (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .wr_data(wr_data), .ctrl_rd(ctrl_rd), .busy(busy), .sample(sample)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word(input bit en, input int a, input int d, input int f);
        return {en, 3'b0, 3'(a), 1'b0, 4'(d), 1'b0, 3'(f)};
    endfunction

    task automatic write(input logic [15:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    // Play a burst with ref_tick held high; checks length, phase pattern and amplitude
    task automatic play(input int a, input int d, input int f);
        int p, n, bad_sign, bad_mag, en_low;
        p = BP << f; n = 0; bad_sign = 0; bad_mag = 0; en_low = 0;
        write(word(1'b1, a, d, f));
        while (busy && n < 100000) begin
            if ((n % p) < p / 2) begin if (sample <= 0) bad_sign++; end
            else if (sample >= 0) bad_sign++;
            if ((sample < 0 ? -int'(sample) : int'(sample)) != (a + 1) * 1024) bad_mag++;
            if (!ctrl_rd[15]) en_low++;
            n++;
            @(negedge clk);
        end
        check(n == 2 * (d + 1) * p, "R4 burst length", n, 2 * (d + 1) * p);
        check(bad_sign == 0, "R3 phase pattern", bad_sign, 0);
        check(bad_mag == 0, "R5 amplitude", bad_mag, 0);
        check(en_low == 0, "R2 enable read during burst", en_low, 0);
        check(ctrl_rd == (word(1'b1, a, d, f) & 16'h0EF7), "R7 self-clear readback",
              int'(ctrl_rd), int'(word(1'b1, a, d, f) & 16'h0EF7));
        check(sample == 0, "R6 idle sample", int'(sample), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(sample == 0, "R1 sample", int'(sample), 0);
        check(ctrl_rd == 16'h0, "R1 readback", int'(ctrl_rd), 0);
    endtask

    task automatic t_reserved();
        write(16'h7108 | word(1'b0, 2, 3, 4));
        check(ctrl_rd == word(1'b0, 2, 3, 4), "R7 reserved bits zero",
              int'(ctrl_rd), int'(word(1'b0, 2, 3, 4)));
        check(busy == 1'b0 && sample == 0, "R6 no start without enable", int'(busy), 0);
    endtask

    task automatic t_restart();
        int n = 0;
        write(word(1'b1, 0, 15, 0));
        repeat (10) @(negedge clk);
        write(word(1'b1, 1, 0, 1));
        while (busy && n < 1000) begin
            if (n < 4) begin if (sample != 2048) n = n + 10000; end
            n++;
            @(negedge clk);
        end
        check(n == 16, "R8 restart length and new amplitude", n, 16);
    endtask

    task automatic t_stop();
        write(word(1'b1, 7, 15, 7));
        repeat (5) @(negedge clk);
        write(word(1'b0, 5, 6, 1));
        check(busy == 1'b0, "R9 stop busy", int'(busy), 0);
        check(sample == 0, "R9 stop sample", int'(sample), 0);
        check(ctrl_rd == word(1'b0, 5, 6, 1), "R9 stored fields",
              int'(ctrl_rd), int'(word(1'b0, 5, 6, 1)));
    endtask

    task automatic t_slow_tick();
        int n = 0;
        write(word(1'b1, 0, 0, 0));
        while (busy && n < 1000) begin
            n++;
            ref_tick = ~ref_tick;
            @(negedge clk);
        end
        ref_tick = 1'b1;
        check(n == 16, "R10 half-rate tick length", n, 16);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                checks++; fails++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        play(0, 0, 0);
        play(3, 5, 2);
        play(7, 15, 7);
        t_reserved();
        t_restart();
        t_stop();
        t_slow_tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule